// File: doc/BRIEF.md
# Shared-Arithmetic RGB to YUV Pixel Converter

This block turns one 8-bit red, green and blue sample into an 8-bit luma value (Y) and two 8-bit chroma values (U, V). It computes nine coefficient products and the additions that combine them. These operations run over several clock cycles on a small pool of multiplier and adder units, set by the parameter `NUM_UNITS`. Only two pools are supported: one multiplier with one adder, or three multipliers with three adders.

A controller FSM replays a fixed operation schedule. It drives the multiplexer selects and register load strobes of a separate datapath and computes no data itself. The datapath holds the arithmetic units, the operand multiplexers, product and accumulator registers, a coefficient ROM and a rounding and saturation output stage.

A pixel enters through a valid/ready handshake. After a fixed number of cycles, which depends on the unit count, the result is announced by a one-cycle valid pulse.

Top module: `rgb2yuv_conv`

## Requirements
- R1: A synchronous active-high `rst` clears `outY`, `outU`, `outV` and `outValid` to 0 and leaves the block idle with `inReady` = 1.
- R2: A pixel is accepted on a rising edge where `inValid` and `inReady` are both 1. `inReady` is 1 exactly when the block is idle. It drops to 0 from the accepting edge until the cycle in which `outValid` pulses. `inValid` and the pixel inputs are ignored while `inReady` is 0.
- R3: `outValid` is set by the rising edge 3·(3/`NUM_UNITS`)+2 edges after the accepting edge. Exactly one pulse is produced per accepted pixel.
- R4: `outValid` is high for exactly one cycle. `outY`, `outU` and `outV` change only in the cycle of that pulse and hold their value until the next pulse.
- R5: `outY` = clamp(0..255, (77·R + 150·G + 29·B + 128) >> 8), using an arithmetic shift. The coefficients are signed values with 8 fraction bits.
- R6: `outU` = clamp(0..255, ((−38·R − 74·G + 112·B + 128) >> 8) + 128), using an arithmetic shift.
- R7: `outV` = clamp(0..255, ((157·R − 132·G − 26·B + 128) >> 8) + 128), using an arithmetic shift. Saturation is reached at both ends, for example pure red gives 255 and cyan gives 0.
- R8: Every product and partial sum is held in an `ACC_W`-bit signed register (20 bits by default) with no overflow for any 8-bit input. The magnitude always stays below 2^(`ACC_W`−2).
- R9: `NUM_UNITS` = 1 builds one multiplier and one adder and needs 11 cycles per pixel. `NUM_UNITS` = 3 builds three of each and needs 5 cycles. In both cases the red and green products of every component are issued before any blue product, because they lie on the longer path to the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A pixel is offered on inR/inG/inB |
| inR | input | 8 | Red sample |
| inG | input | 8 | Green sample |
| inB | input | 8 | Blue sample |
| inReady | output | 1 | Block is idle and will accept a pixel |
| outValid | output | 1 | One-cycle pulse: outY/outU/outV hold a new result |
| outY | output | 8 | Luma result |
| outU | output | 8 | Blue-difference chroma, offset by 128 |
| outV | output | 8 | Red-difference chroma, offset by 128 |

## Verification
The assertions check four properties on every cycle:
- the accumulators stay within their headroom;
- the latched pixel and the output registers change only on their load strobes;
- `outValid` never lasts two cycles;
- each pulse falls exactly the configured number of edges after its accepting edge.

The bench covers what only the scenarios can show. It checks bit-exact Y/U/V values, including saturation at both ends. It checks that offers made while busy are ignored and that the results hold between pulses. It also checks the cycle difference between the one-unit and three-unit builds, by running both against the same input stream.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

  localparam int PIX_W = 8;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       pixLoad;
    logic       mulEn;
    logic [1:0] mulChan;  // 0 red, 1 green, 2 blue
    logic [1:0] mulSlot;  // component index local to a unit
    logic       addEn;
    logic [1:0] addChan;  // channel of the product being added; 0 selects a zero operand
    logic [1:0] addSlot;
    logic       outLoad;
  } ctl_t;

  // Coefficients with 8 fraction bits; comp 0 = Y, 1 = U, 2 = V.
  function automatic int coefOf(input int comp, input int chan);
    int c;
    c = 0;
    case (comp)
      0: case (chan) 0: c = 77;  1: c = 150;  2: c = 29;  default: c = 0; endcase
      1: case (chan) 0: c = -38; 1: c = -74;  2: c = 112; default: c = 0; endcase
      2: case (chan) 0: c = 157; 1: c = -132; 2: c = -26; default: c = 0; endcase
      default: c = 0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/yuv_coef_rom.sv
module yuv_coef_rom
  import rgb2yuv_pkg::*;
#(
  parameter int COEF_W    = 10,
  parameter int UNIT      = 0,
  parameter int NUM_UNITS = 1
) (
  input  logic [1:0]               slot,
  input  logic [1:0]               chan,
  output logic signed [COEF_W-1:0] coef
);

  always_comb begin
    coef = COEF_W'(coefOf(int'(slot) * NUM_UNITS + UNIT, int'(chan)));
  end

endmodule

// File: rtl/yuv_ctrl.sv
module yuv_ctrl
  import rgb2yuv_pkg::*;
#(
  parameter int NUM_UNITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output logic inReady,
  output logic outValid,
  output ctl_t ctl
);

  localparam int SLOTS     = 3 / NUM_UNITS;
  localparam int MUL_STEPS = 3 * SLOTS;
  localparam int LAST_STEP = MUL_STEPS + 1;
  localparam int LATENCY   = LAST_STEP + 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t            state;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      step     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (inValid) begin
            state <= S_RUN;
            step  <= '0;
          end
        end
        default: begin
          if (step == STEP_W'(LAST_STEP)) begin
            state    <= S_IDLE;
            outValid <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end

  assign inReady = (state == S_IDLE);

  // Static schedule: channel-major, so all red and green products precede blue.
  always_comb begin
    int s;
    s   = int'(step);
    ctl = '0;
    ctl.pixLoad = (state == S_IDLE) && inValid;
    if (state == S_RUN) begin
      if (s < MUL_STEPS) begin
        ctl.mulEn   = 1'b1;
        ctl.mulChan = 2'(s / SLOTS);
        ctl.mulSlot = 2'(s % SLOTS);
      end
      if (s >= 1 && s <= MUL_STEPS) begin
        ctl.addEn   = 1'b1;
        ctl.addChan = 2'((s - 1) / SLOTS);
        ctl.addSlot = 2'((s - 1) % SLOTS);
      end
      if (s == LAST_STEP) ctl.outLoad = 1'b1;
    end
  end

  // Cycle counter for the latency check.
  int latCnt;
  always_ff @(posedge clk) begin
    if (rst)                latCnt <= 0;
    else if (ctl.pixLoad)   latCnt <= 1;
    else if (outValid)      latCnt <= 0;
    else if (latCnt != 0)   latCnt <= latCnt + 1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (latCnt == LATENCY + 1))
    else $error("result pulse at wrong distance from acceptance");

  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid)
    else $error("result pulse longer than one cycle");

endmodule

// File: rtl/yuv_datapath.sv
module yuv_datapath
  import rgb2yuv_pkg::*;
#(
  parameter int NUM_UNITS = 1,
  parameter int COEF_W    = 10,
  parameter int FRAC      = 8,
  parameter int ACC_W     = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [PIX_W-1:0] pixRIn,
  input  logic [PIX_W-1:0] pixGIn,
  input  logic [PIX_W-1:0] pixBIn,
  output logic [PIX_W-1:0] yOut,
  output logic [PIX_W-1:0] uOut,
  output logic [PIX_W-1:0] vOut
);

  localparam int SLOTS = 3 / NUM_UNITS;
  localparam logic signed [ACC_W-1:0] RND   = ACC_W'(1 << (FRAC - 1));
  localparam logic signed [ACC_W-1:0] MID   = ACC_W'(1 << (PIX_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'(1 << (ACC_W - 2));

  logic [PIX_W-1:0] pixR, pixG, pixB;
  logic signed [ACC_W-1:0] accWire [NUM_UNITS][SLOTS];
  logic signed [ACC_W-1:0] accAll  [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      pixR <= '0;
      pixG <= '0;
      pixB <= '0;
    end else if (ctl.pixLoad) begin
      pixR <= pixRIn;
      pixG <= pixGIn;
      pixB <= pixBIn;
    end
  end

  assert_pix_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl.pixLoad |=> $stable(pixR) && $stable(pixG) && $stable(pixB))
    else $error("latched pixel changed while busy");

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic signed [COEF_W-1:0] coef;
    logic [PIX_W-1:0]         opnd;
    logic signed [ACC_W-1:0]  prodReg;
    logic signed [ACC_W-1:0]  accLoc [SLOTS];

    yuv_coef_rom #(
      .COEF_W   (COEF_W),
      .UNIT     (u),
      .NUM_UNITS(NUM_UNITS)
    ) i_rom (
      .slot(ctl.mulSlot),
      .chan(ctl.mulChan),
      .coef(coef)
    );

    always_comb begin
      case (ctl.mulChan)
        2'd0:    opnd = pixR;
        2'd1:    opnd = pixG;
        default: opnd = pixB;
      endcase
    end

    // Shared multiplier.
    always_ff @(posedge clk) begin
      if (rst)            prodReg <= '0;
      else if (ctl.mulEn) prodReg <= ACC_W'($signed({1'b0, opnd})) * ACC_W'(coef);
    end

    // Shared adder; the first product of a component meets a zero operand.
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < SLOTS; j++) accLoc[j] <= '0;
      end else if (ctl.addEn) begin
        for (int j = 0; j < SLOTS; j++) begin
          if (int'(ctl.addSlot) == j)
            accLoc[j] <= ((ctl.addChan == 2'd0) ? '0 : accLoc[j]) + prodReg;
        end
      end
    end

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign accWire[u][j] = accLoc[j];

      assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (accLoc[j] < BOUND) && (accLoc[j] > -BOUND))
        else $error("accumulator left its headroom");
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_map
    assign accAll[c] = accWire[c % NUM_UNITS][c / NUM_UNITS];
  end

  function automatic logic [PIX_W-1:0] finishComp(input logic signed [ACC_W-1:0] acc,
                                                  input logic offs);
    logic signed [ACC_W-1:0] t;
    t = (acc + RND) >>> FRAC;
    if (offs) t = t + MID;
    if (t < 0)         return '0;
    else if (t > MAXV) return '1;
    else               return t[PIX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      yOut <= '0;
      uOut <= '0;
      vOut <= '0;
    end else if (ctl.outLoad) begin
      yOut <= finishComp(accAll[0], 1'b0);
      uOut <= finishComp(accAll[1], 1'b1);
      vOut <= finishComp(accAll[2], 1'b1);
    end
  end

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl.outLoad |=> $stable(yOut) && $stable(uOut) && $stable(vOut))
    else $error("result changed without a load strobe");

endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv
  import rgb2yuv_pkg::*;
#(
  parameter int NUM_UNITS = 1,
  parameter int COEF_W    = 10,
  parameter int FRAC      = 8,
  parameter int ACC_W     = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inR,
  input  logic [7:0] inG,
  input  logic [7:0] inB,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outY,
  output logic [7:0] outU,
  output logic [7:0] outV
);

  if (!(NUM_UNITS == 1 || NUM_UNITS == 3)) begin : g_bad_cfg
    $error("NUM_UNITS must be 1 or 3");
  end

  ctl_t ctl;

  yuv_ctrl #(.NUM_UNITS(NUM_UNITS)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .ctl     (ctl)
  );

  yuv_datapath #(
    .NUM_UNITS(NUM_UNITS),
    .COEF_W   (COEF_W),
    .FRAC     (FRAC),
    .ACC_W    (ACC_W)
  ) i_datapath (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .pixRIn(inR),
    .pixGIn(inG),
    .pixBIn(inB),
    .yOut  (outY),
    .uOut  (outU),
    .vOut  (outV)
  );

endmodule

// File: tb/test_rgb2yuv_conv.sv
module test_rgb2yuv_conv;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inR = '0, inG = '0, inB = '0;

  logic       rdy [2];
  logic       ov  [2];
  logic [7:0] oy  [2];
  logic [7:0] ou  [2];
  logic [7:0] ovv [2];

  rgb2yuv_conv #(.NUM_UNITS(1)) i_rgb2yuv_conv (
    .clk(clk), .rst(rst), .inValid(inValid), .inR(inR), .inG(inG), .inB(inB),
    .inReady(rdy[0]), .outValid(ov[0]), .outY(oy[0]), .outU(ou[0]), .outV(ovv[0])
  );

  rgb2yuv_conv #(.NUM_UNITS(3)) i_rgb2yuv_conv_par (
    .clk(clk), .rst(rst), .inValid(inValid), .inR(inR), .inG(inG), .inB(inB),
    .inReady(rdy[1]), .outValid(ov[1]), .outY(oy[1]), .outU(ou[1]), .outV(ovv[1])
  );

  // Latency per requirement R9: 3*(3/N)+2 edges.
  localparam int LAT0 = 3 * (3 / 1) + 2;
  localparam int LAT1 = 3 * (3 / 3) + 2;

  typedef struct {
    int due;
    int y;
    int u;
    int v;
  } exp_t;

  exp_t expQ [2][$];
  int   lastY [2];
  int   lastU [2];
  int   lastV [2];
  int   cyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc++;

  function automatic int clamp8(input int x);
    if (x < 0)   return 0;
    if (x > 255) return 255;
    return x;
  endfunction

  task automatic refPixel(input int r, input int g, input int b,
                          output int y, output int u, output int v);
    int sy, su, sv;
    sy = 77 * r + 150 * g + 29 * b;
    su = -38 * r - 74 * g + 112 * b;
    sv = 157 * r - 132 * g - 26 * b;
    y = clamp8((sy + 128) >>> 8);
    u = clamp8(((su + 128) >>> 8) + 128);
    v = clamp8(((sv + 128) >>> 8) + 128);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle model of one build, evaluated between clock edges.
  task automatic monitorDut(input int idx, input int lat);
    bit   expOv;
    exp_t e;
    int   y, u, v;
    expOv = (expQ[idx].size() > 0) && (expQ[idx][0].due == cyc);
    check($sformatf("R3 R9 R4 outValid timing, build %0d", idx), int'(ov[idx]), int'(expOv));
    if (expOv) begin
      e = expQ[idx].pop_front();
      if (ov[idx]) begin
        check($sformatf("R5 R8 Y, build %0d", idx), int'(oy[idx]), e.y);
        check($sformatf("R6 R8 U, build %0d", idx), int'(ou[idx]), e.u);
        check($sformatf("R7 R8 V, build %0d", idx), int'(ovv[idx]), e.v);
        lastY[idx] = e.y;
        lastU[idx] = e.u;
        lastV[idx] = e.v;
      end
    end else if (!ov[idx]) begin
      check($sformatf("R4 Y hold, build %0d", idx), int'(oy[idx]), lastY[idx]);
      check($sformatf("R4 U hold, build %0d", idx), int'(ou[idx]), lastU[idx]);
      check($sformatf("R4 V hold, build %0d", idx), int'(ovv[idx]), lastV[idx]);
    end
    check($sformatf("R2 inReady, build %0d", idx), int'(rdy[idx]), int'(expQ[idx].size() == 0));
    if (inValid && rdy[idx]) begin
      refPixel(int'(inR), int'(inG), int'(inB), y, u, v);
      e.due = cyc + 1 + lat;
      e.y = y;
      e.u = u;
      e.v = v;
      expQ[idx].push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      monitorDut(0, LAT0);
      monitorDut(1, LAT1);
    end
  end

  task automatic sendPixel(input int r, input int g, input int b);
    @(posedge clk);
    #2;
    inValid = 1'b0;
    while (!(rdy[0] && rdy[1])) begin
      @(posedge clk);
      #2;
    end
    inR = 8'(r);
    inG = 8'(g);
    inB = 8'(b);
    inValid = 1'b1;
    @(posedge clk);
    #2;
    inValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      lastY[i] = 0;
      lastU[i] = 0;
      lastV[i] = 0;
    end
    rst = 1'b1;
    inValid = 1'b1;  // must be ignored under reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("R1 reset outValid", int'(ov[i]), 0);
      check("R1 reset inReady", int'(rdy[i]), 1);
      check("R1 reset Y", int'(oy[i]), 0);
      check("R1 reset U", int'(ou[i]), 0);
      check("R1 reset V", int'(ovv[i]), 0);
    end
    @(posedge clk);
    #2;
    inValid = 1'b0;
    rst = 1'b0;

    // Corners: black, white, primaries, and the saturating V cases (R7, R8).
    sendPixel(0, 0, 0);
    sendPixel(255, 255, 255);
    sendPixel(255, 0, 0);
    sendPixel(0, 255, 0);
    sendPixel(0, 0, 255);
    sendPixel(0, 255, 255);
    sendPixel(255, 255, 0);
    sendPixel(128, 64, 200);

    // Free-running offers, many while busy (R2 ignore), with frequent extremes.
    repeat (900) begin
      @(posedge clk);
      #2;
      inValid = 1'($urandom_range(0, 1));
      inR = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      inG = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      inB = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
    end
    @(posedge clk);
    #2;
    inValid = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    #1;
    for (int i = 0; i < 2; i++)
      check("R3 every accepted pixel produced a result", expQ[i].size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule